// File: doc/BRIEF.md
# Framing Byte Burst Corruptor

This block sits in a transmit byte stream and deliberately damages the framing pattern so that a far-end receiver's loss-of-frame alarms can be tested. A processor writes a 5-bit burst length and pulses a trigger. The block then inverts every bit of the first A2 framing byte in each of a run of consecutive frames. All other bytes pass through unchanged.

The stream arrives one byte per clock. A start-of-frame strobe marks the first byte of each frame. An A2 strobe is high for every A2 byte. The block takes the first A2 byte after each start-of-frame as the one to corrupt. Output data has one register stage of latency. A busy flag shows when a burst is armed or running.

Top module: `a2_burst_inserter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy` is 0 and `dout` is 0x00.
- R2: A burst length value N (0 to 31) corrupts exactly N+1 frames. These are consecutive frames, with no gap between them.
- R3: A corrupted byte is the bitwise inverse of the input byte. A framing value of 0x28 is therefore sent as 0xD7.
- R4: The first corrupted byte is the first A2 byte of the next frame whose first A2 byte arrives in a later cycle than the accepted trigger. If the trigger falls in the same cycle as a first A2 byte, that byte is not corrupted.
- R5: A trigger that arrives while `busy` is 1 has no effect. This includes a trigger in the cycle of the final corrupted byte. Such a trigger changes neither the count of corrupted frames nor the `busy` waveform.
- R6: `busy` rises in the cycle after an accepted trigger. It stays high through the cycle in which the last corrupted byte is presented at `din`, and falls in the next cycle.
- R7: Every byte that is not corrupted reaches `dout` unchanged, one cycle after it was at `din`. This covers the second and third A2 bytes and all bytes outside a burst.
- R8: The inversion does not depend on the byte's value. A first A2 byte that is not 0x28 is inverted as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Transmit byte in |
| sof | input | 1 | High on the first byte of each frame |
| a2_byte | input | 1 | High on each A2 framing byte |
| burst_len | input | 5 | Frames to corrupt, minus one; sampled when a trigger is accepted |
| trig | input | 1 | One-cycle request to start a burst |
| dout | output | 8 | Transmit byte out, registered |
| busy | output | 1 | Burst armed or in progress |

## Verification
Two pairs of functions can fall in the same cycle:
- An idle trigger can coincide with a first A2 byte. That slot must pass clean, and the burst must start one frame later.
- A trigger can arrive on the very A2 byte that ends a burst. It must be dropped, and `busy` must still fall.

The bench places each trial's trigger at a different byte position of the frame, so the first case occurs at position 3. It raises the second case on purpose in every trial, together with an extra trigger shortly after each start. Each is judged from the corrupted-frame count for the trial and from the cycle-exact `busy` and `dout` predictions.

// File: rtl/a2i_pkg.sv
package a2i_pkg;
    localparam int A2I_DW = 8;
    localparam int A2I_CW = 5;

    typedef logic [A2I_DW-1:0] byte_t;
    typedef logic [A2I_CW-1:0] cnt_t;

    typedef struct packed {
        logic busy;
        cnt_t left;
    } burst_t;

    localparam burst_t BURST_IDLE = '{busy: 1'b0, left: '0};

    function automatic byte_t a2i_flip(input byte_t b, input logic en);
        return en ? ~b : b;
    endfunction
endpackage

// File: rtl/a2i_locate.sv
module a2i_locate (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic a2_byte,
    output logic a2_first
);
    logic seen_q;

    assign a2_first = a2_byte && (sof || !seen_q);

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= 1'b0;
        else if (sof)
            seen_q <= a2_byte;
        else
            seen_q <= seen_q | a2_byte;
    end
endmodule

// File: rtl/a2i_burst.sv
module a2i_burst
    import a2i_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  cnt_t burst_len,
    input  logic a2_first,
    output logic busy,
    output cnt_t left,
    output logic hit
);
    burst_t st_q, st_d;

    assign hit  = st_q.busy && a2_first;
    assign busy = st_q.busy;
    assign left = st_q.left;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (trig) begin
                st_d.busy = 1'b1;
                st_d.left = burst_len;
            end
        end else if (hit) begin
            if (st_q.left == '0)
                st_d = BURST_IDLE;
            else
                st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= BURST_IDLE;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/a2i_mod.sv
module a2i_mod
    import a2i_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t din,
    input  logic  hit,
    output byte_t dout
);
    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else
            dout <= a2i_flip(din, hit);
    end
endmodule

// File: rtl/a2_burst_inserter.sv
module a2_burst_inserter
    import a2i_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] din,
    input  logic       sof,
    input  logic       a2_byte,
    input  logic [4:0] burst_len,
    input  logic       trig,
    output logic [7:0] dout,
    output logic       busy
);
    logic a2_first;
    logic hit;
    cnt_t left_cnt;

    a2i_locate u_loc (
        .clk      (clk),
        .rst      (rst),
        .sof      (sof),
        .a2_byte  (a2_byte),
        .a2_first (a2_first)
    );

    a2i_burst u_ctl (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .burst_len (burst_len),
        .a2_first  (a2_first),
        .busy      (busy),
        .left      (left_cnt),
        .hit       (hit)
    );

    a2i_mod u_mod (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .hit  (hit),
        .dout (dout)
    );
endmodule

// File: rtl/a2i_chk.sv
module a2i_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] din,
    input logic       trig,
    input logic [7:0] dout,
    input logic       busy,
    input logic       a2_first,
    input logic [4:0] left_cnt
);
    AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (rst)
        (!busy && trig) |=> busy); // R6
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !trig) |=> !busy); // R4
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !a2_first) |=> (busy && $stable(left_cnt))); // R5
    AST_LAST_DROPS: assert property (@(posedge clk) disable iff (rst)
        (busy && a2_first && left_cnt == 5'd0) |=> !busy); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && a2_first && left_cnt != 5'd0) |=> (busy && left_cnt == $past(left_cnt) - 5'd1)); // R2
    AST_INVERT: assert property (@(posedge clk) disable iff (rst)
        (busy && a2_first) |=> (dout == ~$past(din))); // R3
    AST_PASS: assert property (@(posedge clk) disable iff (rst)
        !(busy && a2_first) |=> (dout == $past(din))); // R7
endmodule

bind a2_burst_inserter a2i_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .trig     (trig),
    .dout     (dout),
    .busy     (busy),
    .a2_first (a2_first),
    .left_cnt (left_cnt)
);

// File: tb/sim_a2_burst_inserter.sv
module sim_a2_burst_inserter;
    localparam int PERIOD = 10;
    localparam int FL     = 12;
    localparam int A2POS  = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic       sof = 1'b0;
    logic       a2_byte = 1'b0;
    logic [4:0] burst_len = 5'd0;
    logic       trig = 1'b0;
    logic [7:0] dout;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int g = 0;
    int tc = -1;
    int lastc = -1;
    int obs_inv = 0;

    always #(PERIOD/2) clk = ~clk;

    a2_burst_inserter u0 (
        .clk(clk), .rst(rst), .din(din), .sof(sof), .a2_byte(a2_byte),
        .burst_len(burst_len), .trig(trig), .dout(dout), .busy(busy)
    );

    function automatic logic [7:0] gen(input int gc);
        int pos = gc % FL;
        int fr = gc / FL;
        if (pos < A2POS) return 8'hF6;
        if (pos == A2POS && fr % 5 == 2) return 8'((fr * 37) & 8'hFF) | 8'h01;
        if (pos <= A2POS + 2) return 8'h28;
        return 8'((gc * 13 + 5) & 8'hFF);
    endfunction

    function automatic bit exp_busy(input int x);
        return (x > tc) && (x <= lastc);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, g);
        end
    endtask

    task automatic step(input logic t, input logic [4:0] bl);
        int pos = g % FL;
        logic [7:0] d;
        logic [7:0] e;
        bit inv;
        string tag;
        d = gen(g);
        din = d; sof = (pos == 0); a2_byte = (pos >= A2POS && pos <= A2POS + 2);
        trig = t; burst_len = bl;
        if (t && !exp_busy(g)) begin
            tc = g;
            lastc = ((pos < A2POS) ? g / FL : g / FL + 1) * FL + A2POS + bl * FL;
        end
        inv = (pos == A2POS) && exp_busy(g);
        e = inv ? ~d : d;
        if (inv) tag = (d == 8'h28) ? "R3" : "R8";
        else if (pos == A2POS && tc == g) tag = "R4";
        else tag = "R7";
        @(posedge clk);
        @(negedge clk);
        g++;
        trig = 1'b0;
        if (dout == ~d) obs_inv++;
        check(dout == e, tag, dout, e);
        if (inv && d == 8'h28) check(dout == 8'hD7, "R3", dout, 8'hD7);
        check(busy == exp_busy(g), "R6", busy, exp_busy(g));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1", busy, 0);
        check(dout == 8'h00, "R1", dout, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1", busy, 0);
        check(dout == 8'h00, "R1", dout, 0);
        g = 0;
        for (int k = 0; k < 32; k++) begin
            int start_tc;
            while (g % FL != k % FL) step(1'b0, 5'd0);
            obs_inv = 0;
            start_tc = g;
            step(1'b1, 5'(k));
            // R5: extra triggers mid-burst and on the final corrupted slot
            while (g <= lastc + 1) step((g == start_tc + 5) || (g == lastc), (g == lastc) ? 5'd0 : 5'd31);
            check(obs_inv == k + 1, "R2", obs_inv, k + 1);
            check(tc == start_tc, "R5", tc, start_tc);
            repeat (FL + 2) step(1'b0, 5'd7);
        end
        finish_run();
    end
endmodule